// File: doc/BRIEF.md
# Flash Instruction Sequence Interpreter

This block runs short programs that describe one transaction on a serial flash bus. A small table holds several sequences of 16-bit instructions. A start strobe names a sequence. The block then steps through that sequence one instruction at a time. For each instruction it asks a downstream shifter to perform one bus phase: a command, an address, mode bits, dummy cycles, or read or write data. Each request carries the lane count and a flag that says whether the phase runs at single or double data rate. Chip select stays active for as long as the sequence runs.

A sequence ends in one of three ways: at a halt instruction, at a jump instruction, or after its eighth instruction. A jump instruction also leaves behind a start point for the next transaction. The block refuses instruction mixes that the bus cannot carry out. When it finds one, it drops chip select at once and latches an error code together with the sequence number until software clears it. The pad shifter, the bus interface that issues the start and the data FIFOs are outside the block. Each phase is handed over with a valid/ready handshake.

Top module: `flash_seq_engine`

## Requirements
- R1: The table word at address `s*4+w` holds instruction `2w` of sequence `s` in bits 15:0 and instruction `2w+1` in bits 31:16. Each instruction is opcode[15:10], pad code[9:8] and operand[7:0]. A table write is one 32-bit word per cycle, and after reset every table word is zero.
- R2: An opcode is a phase opcode when its bit 4 is 0 and its low nibble is 1 to 13. For a phase opcode, `phase_code` is the low nibble of the opcode, `phase_ddr` is opcode bit 5 and `phase_arg` is the operand. The low nibble values are: 1 command, 2 row address, 3 column address, 4 to 7 mode bits, 8 write, 9 read, 10 learn, 11 data size, 12 dummy, 13 dummy timed by the strobe.
- R3: `phase_lanes` is one-hot: 1 lane gives 0001, 2 lanes give 0010, 4 lanes give 0100 and 8 lanes give 1000. The lane count is `1 << pad code`.
- R4: A phase request, once raised, stays up with unchanged fields until `phase_ready` is seen. Each accepted phase advances the block by exactly one instruction.
- R5: Opcode 0x00 ends the sequence. `cs_active` goes low and `done` pulses for one cycle. `cs_active` goes high in the cycle after an accepted start.
- R6: Opcode 0x1F started with `allow_jump` high ends the sequence like a halt. It also stores the operand as a table-wide instruction index (`s*8+n`). The next start then begins at that index instead of at `seq_idx*8`, and the stored index is used only once. Started with `allow_jump` low, opcode 0x1F raises error code 0x2.
- R7: Any opcode that is neither a phase opcode, 0x00 nor 0x1F raises error code 0x3.
- R8: The first phase instruction of a run fixes the run's data-rate mode. A later dummy (low nibble 12 or 13) of the single-rate family in a double-rate run raises error code 0x4. A later dummy of the double-rate family in a single-rate run raises error code 0x5.
- R9: A sequence whose eight instructions are all accepted phases ends with `done` after the eighth, as if a halt followed it.
- R10: On an error, chip select drops in the same cycle that `err_valid` rises, and no `done` pulse occurs. `err_code` and `err_seq` hold until `err_clear` is pulsed, and clearing sets `err_valid` low.
- R11: A start is ignored while a sequence runs or while an error is latched.
- R12: After reset, `cs_active`, `done`, `phase_valid` and `err_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Table word write enable |
| tbl_addr | input | 4 | Table word address |
| tbl_wdata | input | 32 | Table word data (two instructions) |
| start | input | 1 | Start a sequence |
| seq_idx | input | 2 | Sequence number sampled at start |
| allow_jump | input | 1 | This command may use the jump instruction |
| phase_valid | output | 1 | Phase request to the shifter |
| phase_ready | input | 1 | Shifter accepts the phase |
| phase_code | output | 4 | Phase type (opcode low nibble) |
| phase_ddr | output | 1 | Phase uses double data rate |
| phase_lanes | output | 4 | One-hot lane count |
| phase_arg | output | 8 | Instruction operand |
| cs_active | output | 1 | Chip select asserted |
| done | output | 1 | One-cycle pulse at normal sequence end |
| err_valid | output | 1 | Error latched |
| err_code | output | 4 | Latched error code |
| err_seq | output | 2 | Sequence number of the failing run |
| err_clear | input | 1 | Clear the latched error |

## Verification
The inline assertions check rules that hold every cycle. They cover the one-hot lane output, that requests appear only under chip select, that a stalled request stays stable, that an error never coexists with chip select and stays fixed until cleared, and that `done` follows the drop of chip select. The bench's scenarios show what the table contents decide. It sweeps all 64 opcodes through the decoder and crosses first-phase families with every dummy variant. It also exercises the one-shot jump start point, the eight-instruction cap, and the refusal of starts while busy or while an error is latched.

// File: rtl/flash_seq_pkg.sv
// Shared types for the flash instruction sequence interpreter.
// Assumes a 16-bit instruction made of a 6-bit opcode, a 2-bit pad code
// and an 8-bit operand.
package flash_seq_pkg;
    localparam logic [5:0] OP_HALT = 6'h00;
    localparam logic [5:0] OP_JUMP = 6'h1F;

    typedef struct packed {
        logic [5:0] op;
        logic [1:0] pad;
        logic [7:0] arg;
    } instr_t;

    typedef enum logic [1:0] {
        K_HALT  = 2'd0,
        K_JUMP  = 2'd1,
        K_PHASE = 2'd2,
        K_BAD   = 2'd3
    } ikind_t;

    typedef enum logic [3:0] {
        E_NONE      = 4'h0,
        E_JUMP      = 4'h2,
        E_BADOP     = 4'h3,
        E_SDR_DUMMY = 4'h4,
        E_DDR_DUMMY = 4'h5
    } err_t;
endpackage

// File: rtl/seq_table.sv
// Instruction table: word-wide writes, instruction-wide reads.
// Assumes SEQ_LEN is a power of two and even. Two instructions share one
// word, and the low half holds the even one. Reset clears every word.
module seq_table #(
    parameter int NUM_SEQ = 4,
    parameter int SEQ_LEN = 8,
    localparam int WORDS  = NUM_SEQ * SEQ_LEN / 2,
    localparam int AW     = $clog2(WORDS),
    localparam int IW     = $clog2(NUM_SEQ * SEQ_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [31:0]          wdata,
    input  logic [IW-1:0]        rd_idx,
    output flash_seq_pkg::instr_t rd_instr
);
    logic [31:0] mem [WORDS];
    logic [31:0] word;

    // Storage: clear on reset, otherwise take one word per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read: pick the word, then the half chosen by the index LSB.
    always_comb begin
        word     = mem[rd_idx[IW-1:1]];
        rd_instr = rd_idx[0] ? word[31:16] : word[15:0];
    end
endmodule

// File: rtl/seq_decode.sv
// Instruction classifier: halt, jump, legal phase or unknown opcode.
// It also flags dummy phases, extracts the data-rate bit and turns the
// pad code into a one-hot lane count. It is purely combinational.
module seq_decode (
    input  flash_seq_pkg::instr_t  instr,
    output flash_seq_pkg::ikind_t  kind,
    output logic                   is_dummy,
    output logic                   ddr,
    output logic [3:0]             lanes
);
    import flash_seq_pkg::*;
    logic [3:0] lo;

    // Classification of the opcode field.
    always_comb begin
        lo       = instr.op[3:0];
        ddr      = instr.op[5];
        is_dummy = (lo == 4'd12) || (lo == 4'd13);
        lanes    = 4'd1 << instr.pad;
        if (instr.op == OP_HALT)                            kind = K_HALT;
        else if (instr.op == OP_JUMP)                       kind = K_JUMP;
        else if (!instr.op[4] && lo != 4'd0 && lo <= 4'd13) kind = K_PHASE;
        else                                                kind = K_BAD;
    end
endmodule

// File: rtl/seq_ctrl.sv
// Sequencer: instruction pointer, run state, data-rate mode, jump start
// point and error latch. Assumes the table is not rewritten while a run is
// in progress. Starts are refused while busy or while an error is latched.
module seq_ctrl #(
    parameter int NUM_SEQ = 4,
    parameter int SEQ_LEN = 8,
    localparam int SW = $clog2(NUM_SEQ),
    localparam int LW = $clog2(SEQ_LEN),
    localparam int IW = SW + LW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [SW-1:0]         seq_idx,
    input  logic                  allow_jump,
    input  logic                  err_clear,
    input  flash_seq_pkg::ikind_t kind,
    input  logic                  is_dummy,
    input  logic                  ddr,
    input  logic [7:0]            arg,
    input  logic                  phase_ready,
    output logic [IW-1:0]         ptr,
    output logic                  phase_valid,
    output logic                  cs_active,
    output logic                  done,
    output logic                  err_valid,
    output logic [3:0]            err_code,
    output logic [SW-1:0]         err_seq
);
    import flash_seq_pkg::*;

    logic          busy_q, allow_q, mode_set_q, mode_ddr_q, jmp_valid_q, done_q, err_q;
    logic [IW-1:0] ptr_q, jmp_ptr_q;
    logic [LW-1:0] cnt_q;
    logic [SW-1:0] seq_q, err_seq_q;
    err_t          err_code_q, fault_code;
    logic          clash, fault, accept, finish, go;

    // Decision logic for the instruction at the pointer.
    always_comb begin
        clash       = (kind == K_PHASE) && is_dummy && mode_set_q && (ddr != mode_ddr_q);
        phase_valid = busy_q && (kind == K_PHASE) && !clash;
        accept      = phase_valid && phase_ready;
        fault       = busy_q && ((kind == K_BAD) || (kind == K_JUMP && !allow_q) || clash);
        finish      = busy_q && ((kind == K_HALT) || (kind == K_JUMP && allow_q)
                                 || (accept && cnt_q == LW'(SEQ_LEN - 1)));
        go          = start && !busy_q && !err_q;
        if (kind == K_BAD)       fault_code = E_BADOP;
        else if (kind == K_JUMP) fault_code = E_JUMP;
        else if (mode_ddr_q)     fault_code = E_SDR_DUMMY;
        else                     fault_code = E_DDR_DUMMY;
    end

    // Run state, pointer, mode, jump point and error latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0; allow_q <= 1'b0; mode_set_q <= 1'b0; mode_ddr_q <= 1'b0;
            jmp_valid_q <= 1'b0; jmp_ptr_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
            ptr_q <= '0; cnt_q <= '0; seq_q <= '0; err_seq_q <= '0; err_code_q <= E_NONE;
        end else begin
            done_q <= finish;
            if (err_clear) begin
                err_q      <= 1'b0;
                err_code_q <= E_NONE;
            end
            if (go) begin
                busy_q      <= 1'b1;
                ptr_q       <= jmp_valid_q ? jmp_ptr_q : {seq_idx, LW'(0)};
                jmp_valid_q <= 1'b0;
                cnt_q       <= '0;
                mode_set_q  <= 1'b0;
                seq_q       <= seq_idx;
                allow_q     <= allow_jump;
            end else if (fault) begin
                busy_q     <= 1'b0;
                err_q      <= 1'b1;
                err_code_q <= fault_code;
                err_seq_q  <= seq_q;
            end else if (finish) begin
                busy_q <= 1'b0;
                if (kind == K_JUMP) begin
                    jmp_valid_q <= 1'b1;
                    jmp_ptr_q   <= IW'(arg);
                end
            end else if (accept) begin
                ptr_q <= ptr_q + 1'b1;
                cnt_q <= cnt_q + 1'b1;
                if (!mode_set_q) begin
                    mode_set_q <= 1'b1;
                    mode_ddr_q <= ddr;
                end
            end
        end
    end

    assign ptr       = ptr_q;
    assign cs_active = busy_q;
    assign done      = done_q;
    assign err_valid = err_q;
    assign err_code  = err_code_q;
    assign err_seq   = err_seq_q;

    // R10: an error never coexists with chip select
    a_r10_err_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !busy_q);
    // R10: latched code and sequence hold until cleared
    a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clear) |=> (err_q && $stable(err_code_q) && $stable(err_seq_q)));
    // R5: the done pulse comes after chip select has dropped
    a_r5_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    // R11: a start during an error is refused
    a_r11_no_start_in_err: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && start) |=> !busy_q);
    // R2: phase requests only under chip select
    a_r2_phase_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid |-> busy_q);
endmodule

// File: rtl/flash_seq_engine.sv
// Top of the flash instruction sequence interpreter. It ties the table,
// the decoder and the sequencer together and presents the current phase
// to the shifter. Assumes NUM_SEQ >= 2 and SEQ_LEN a power of two.
module flash_seq_engine #(
    parameter int NUM_SEQ = 4,
    parameter int SEQ_LEN = 8,
    localparam int SW = $clog2(NUM_SEQ),
    localparam int IW = $clog2(NUM_SEQ * SEQ_LEN),
    localparam int AW = $clog2(NUM_SEQ * SEQ_LEN / 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tbl_we,
    input  logic [AW-1:0] tbl_addr,
    input  logic [31:0]   tbl_wdata,
    input  logic          start,
    input  logic [SW-1:0] seq_idx,
    input  logic          allow_jump,
    output logic          phase_valid,
    input  logic          phase_ready,
    output logic [3:0]    phase_code,
    output logic          phase_ddr,
    output logic [3:0]    phase_lanes,
    output logic [7:0]    phase_arg,
    output logic          cs_active,
    output logic          done,
    output logic          err_valid,
    output logic [3:0]    err_code,
    output logic [SW-1:0] err_seq,
    input  logic          err_clear
);
    import flash_seq_pkg::*;

    instr_t        cur;
    ikind_t        kind;
    logic          is_dummy, ddr;
    logic [3:0]    lanes;
    logic [IW-1:0] ptr;

    seq_table #(.NUM_SEQ(NUM_SEQ), .SEQ_LEN(SEQ_LEN)) u_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr),
        .wdata(tbl_wdata), .rd_idx(ptr), .rd_instr(cur));

    seq_decode u_decode (
        .instr(cur), .kind(kind), .is_dummy(is_dummy), .ddr(ddr), .lanes(lanes));

    seq_ctrl #(.NUM_SEQ(NUM_SEQ), .SEQ_LEN(SEQ_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .seq_idx(seq_idx),
        .allow_jump(allow_jump), .err_clear(err_clear), .kind(kind),
        .is_dummy(is_dummy), .ddr(ddr), .arg(cur.arg), .phase_ready(phase_ready),
        .ptr(ptr), .phase_valid(phase_valid), .cs_active(cs_active), .done(done),
        .err_valid(err_valid), .err_code(err_code), .err_seq(err_seq));

    // Phase fields come straight from the current instruction.
    always_comb begin
        phase_code  = cur.op[3:0];
        phase_ddr   = ddr;
        phase_lanes = lanes;
        phase_arg   = cur.arg;
    end

    // R3: lane count is one-hot during a request
    a_r3_lanes_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid |-> ($countones(phase_lanes) == 1));
    // R4: a stalled request holds its fields
    a_r4_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_valid && !phase_ready && !tbl_we) |=>
        (phase_valid && $stable(phase_arg) && $stable(phase_code) && $stable(phase_lanes)));
endmodule

// File: tb/flash_seq_engine_bench.sv
// Self-checking bench: opcode sweep, dummy/mode matrix, jump, length cap,
// handshake stall and start refusal.
module flash_seq_engine_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic tbl_we = 0; logic [3:0] tbl_addr = 0; logic [31:0] tbl_wdata = 0;
    logic start = 0; logic [1:0] seq_idx = 0; logic allow_jump = 0;
    logic phase_valid; logic phase_ready = 1;
    logic [3:0] phase_code, phase_lanes; logic phase_ddr; logic [7:0] phase_arg;
    logic cs_active, done, err_valid; logic [3:0] err_code; logic [1:0] err_seq;
    logic err_clear = 0;

    int checks = 0, errors = 0;
    bit finished = 0;
    int n_ph; bit end_done, end_err;
    logic [3:0] ph_code [16]; logic ph_ddr [16]; logic [3:0] ph_lanes [16]; logic [7:0] ph_arg [16];

    always #5 clk = ~clk;

    flash_seq_engine u_flash_seq_engine (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .start(start), .seq_idx(seq_idx), .allow_jump(allow_jump), .phase_valid(phase_valid),
        .phase_ready(phase_ready), .phase_code(phase_code), .phase_ddr(phase_ddr),
        .phase_lanes(phase_lanes), .phase_arg(phase_arg), .cs_active(cs_active), .done(done),
        .err_valid(err_valid), .err_code(err_code), .err_seq(err_seq), .err_clear(err_clear));

    task automatic tick; @(posedge clk); #2; endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int op, input int pad, input int arg);
        return {6'(op), 2'(pad), 8'(arg)};
    endfunction

    task automatic wr(input int addr, input logic [31:0] data);
        tbl_we = 1; tbl_addr = 4'(addr); tbl_wdata = data; tick; tbl_we = 0;
    endtask

    task automatic clr_err; err_clear = 1; tick; err_clear = 0; endtask

    task automatic run(input int s, input bit allow);
        n_ph = 0; end_done = 0; end_err = 0;
        seq_idx = 2'(s); allow_jump = allow; start = 1; tick; start = 0;
        for (int c = 0; c < 24; c++) begin
            if (phase_valid && n_ph < 16) begin
                ph_code[n_ph] = phase_code; ph_ddr[n_ph] = phase_ddr;
                ph_lanes[n_ph] = phase_lanes; ph_arg[n_ph] = phase_arg; n_ph++;
            end
            if (done) begin end_done = 1; break; end
            if (err_valid) begin end_err = 1; break; end
            tick;
        end
    endtask

    function automatic bit is_phase(input int op);
        return (op[4] == 1'b0) && (op[3:0] != 0) && (op[3:0] <= 13);
    endfunction

    initial begin
        repeat (3) tick;
        rst_n = 1; tick;
        // R12 reset state
        check(!cs_active && !done && !phase_valid && !err_valid, "R12 reset outputs",
              {cs_active, done, phase_valid, err_valid}, 0);

        // R1 R2 R3 R5 R7 R6: sweep every opcode as the first instruction
        for (int op = 0; op < 64; op++) begin
            wr(0, {16'h0000, mk(op, op % 4, op ^ 8'hA5)});
            run(0, 0);
            if (op == 0) begin
                check(end_done && !end_err && n_ph == 0, "R5 halt ends run", n_ph, 0);
            end else if (op == 31) begin
                check(end_err && err_code == 4'h2, "R6 jump not allowed", err_code, 2);
            end else if (is_phase(op)) begin
                check(end_done && n_ph == 1, "R2 one phase then halt", n_ph, 1);
                check(ph_code[0] == 4'(op) && ph_ddr[0] == op[5] && ph_arg[0] == 8'(op ^ 8'hA5),
                      "R2 phase fields", {ph_ddr[0], ph_code[0], ph_arg[0]},
                      {op[5], 4'(op), 8'(op ^ 8'hA5)});
                check(ph_lanes[0] == 4'(1 << (op % 4)), "R3 lane count", ph_lanes[0], 1 << (op % 4));
            end else begin
                check(end_err && err_code == 4'h3, "R7 unknown opcode", err_code, 3);
            end
            if (end_err) begin
                check(!cs_active && err_seq == 0, "R10 cs low and seq latched",
                      {cs_active, err_seq}, 0);
                clr_err;
                check(!err_valid && err_code == 0, "R10 clear", err_valid, 0);
            end
        end

        // R6 jump: seq1 writes one phase then jumps to index 18 (seq2, instr 2)
        wr(4, {mk(31, 0, 18), mk(8, 0, 8'h11)});
        for (int w = 5; w < 8; w++) wr(w, 0);
        wr(9, {16'h0000, mk(6'h29, 1, 8'h5A)});
        wr(0, {16'h0000, mk(2, 3, 8'h77)});
        run(1, 1);
        check(end_done && !end_err && n_ph == 1 && ph_arg[0] == 8'h11, "R6 jump ends run", ph_arg[0], 8'h11);
        run(0, 0);
        check(end_done && n_ph == 1 && ph_code[0] == 9 && ph_ddr[0] && ph_lanes[0] == 4'b0010 && ph_arg[0] == 8'h5A,
              "R6 next start at jump point", ph_arg[0], 8'h5A);
        run(0, 0);
        check(end_done && n_ph == 1 && ph_code[0] == 2 && ph_lanes[0] == 4'b1000 && ph_arg[0] == 8'h77,
              "R6 jump point used once", ph_arg[0], 8'h77);

        // R9: eight phase instructions with no halt
        for (int w = 0; w < 4; w++)
            wr(12 + w, {mk(1, (2 * w + 1) % 4, 2 * w + 1), mk(1, (2 * w) % 4, 2 * w)});
        run(3, 0);
        check(end_done && !end_err && n_ph == 8, "R9 eight instructions end run", n_ph, 8);
        for (int i = 0; i < 8; i++)
            check(ph_arg[i] == 8'(i) && ph_lanes[i] == 4'(1 << (i % 4)), "R9 R4 phase order",
                  ph_arg[i], i);

        // R8: first-phase family crossed with each dummy variant
        for (int f = 0; f < 4; f++) begin
            for (int d = 0; d < 4; d++) begin
                int fo, dop;
                fo  = (f == 0) ? 6'h01 : (f == 1) ? 6'h21 : (f == 2) ? 6'h0C : 6'h2C;
                dop = (d == 0) ? 6'h0C : (d == 1) ? 6'h0D : (d == 2) ? 6'h2C : 6'h2D;
                wr(8, {mk(dop, 0, 2), mk(fo, 0, 1)});
                wr(9, 0);
                run(2, 0);
                if (fo[5] != dop[5]) begin
                    check(end_err && err_code == (fo[5] ? 4'h4 : 4'h5) && err_seq == 2,
                          "R8 dummy mode clash", err_code, fo[5] ? 4 : 5);
                    check(n_ph == 1 && !done, "R10 no done on error", n_ph, 1);
                    clr_err;
                end else begin
                    check(end_done && !end_err && n_ph == 2, "R8 matching dummy accepted", n_ph, 2);
                end
            end
        end

        // R4 R11: stall a phase, try a start meanwhile
        wr(4, {16'h0000, mk(8, 2, 8'h33)});
        phase_ready = 0;
        seq_idx = 1; start = 1; tick; start = 0;
        check(phase_valid && phase_arg == 8'h33 && phase_lanes == 4'b0100, "R4 request raised", phase_arg, 8'h33);
        seq_idx = 3; start = 1; tick; start = 0;
        for (int i = 0; i < 3; i++) begin
            check(phase_valid && phase_arg == 8'h33, "R4 R11 held while stalled", phase_arg, 8'h33);
            tick;
        end
        phase_ready = 1; tick;
        check(!phase_valid && cs_active, "R4 one step per accept", phase_valid, 0);
        tick;
        check(done && !cs_active, "R5 done after halt", done, 1);
        tick;
        check(!done && !cs_active, "R5 done one cycle, R11 busy start dropped", {done, cs_active}, 0);

        // R11: start refused while an error is latched
        wr(4, {16'h0000, mk(6'h3F, 0, 0)});
        run(1, 0);
        check(end_err && err_code == 4'h3 && err_seq == 1, "R7 error latched", err_code, 3);
        seq_idx = 3; start = 1; tick; start = 0; tick;
        check(!cs_active && !phase_valid && err_code == 4'h3 && err_seq == 1,
              "R11 start ignored in error", {cs_active, err_seq}, 1);
        clr_err;
        check(!err_valid, "R10 cleared", err_valid, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule